// File: doc/BRIEF.md
# Dual-Direction Universal Bus Transceiver Core

This block is the logic core of an 18-bit bidirectional bus transceiver that connects a card-side bus (port A) to a shared backplane bus (port B). Each of the two directions, A-to-B and B-to-A, has its own storage path. That path can pass data straight through, hold a stored word, or capture a word on the rising edge of its own clock. Each direction also has its own active-low output enable. Port A drives as a tri-state output. Port B drives as open-drain: it only pulls lines low and leaves a high bit to the bus pull-up. This lets several transceivers share a wired bus. The A-side inputs carry bus-hold keepers, so an undriven A line keeps its last driven level.

Each storage path picks its mode from its latch enable and clock enable. Three modes exist:
- FLOW: latch enable high. The output follows the input, and every clock edge refreshes the stored word.
- CAPTURE: latch enable low and clock enable low. A rising clock edge loads the input.
- INHIBIT: latch enable low and clock enable high. Clock edges are ignored.

The mode changes as soon as a control input changes. The mode transitions are:
- FLOW to CAPTURE or INHIBIT: latch enable falls. The word stored at the last rising edge of the FLOW interval is kept.
- CAPTURE to INHIBIT and back: clock enable toggles.
- Any mode to FLOW: latch enable rises.

The pads are left to the integrator. The core exposes a separate input, value and enable vector for each port. Clocks are per direction and need not run freely. Reset is asynchronous and active low.

Top module: `ubx_transceiver`

## Requirements
- R1: The two directions are independent and symmetric. A B-to-A path built from `oe_ba_n`, `le_ba`, `ce_ba_n` and `clk_ba` behaves exactly like the A-to-B path, and activity in one direction never changes the other direction's stored word or output.
- R2: While a direction's output enable is high (inactive), its drive enables are all 0: `b_oe` for A-to-B, `a_oe` for B-to-A. This holds whatever the other controls, clocks or data do. The stored word is preserved across the disabled interval.
- R3: With output enable low and latch enable high, the output level equals the current input word, with no clock edge needed.
- R4: With output enable low, latch enable low and clock enable low, a rising clock edge loads the input word, and the output shows it after the edge. A falling edge loads nothing.
- R5: With latch enable low and no rising edge, the output keeps the stored word, whether the clock rests high or low.
- R6: With latch enable low and clock enable high, rising edges are ignored and the stored word is kept.
- R7: Latch enable has priority over the clock. A rising edge while latch enable is high loads the input even when clock enable is high. When latch enable then falls with the clock high, the word loaded at that last edge is kept.
- R8: Port B is open-drain. `b_out` is always 0. While the A-to-B direction is enabled, bit i of `b_oe` is 1 exactly where bit i of the outgoing word is 0. A bit that is 1 is released, and the line rests at the pull-up level 1.
- R9: Bus-hold: where bit i of `a_in_drv` is 0, the A-to-B path uses the last level seen on `a_in[i]` while that bit was driven, instead of the current `a_in[i]`.
- R10: Asynchronous reset (`rst_n` low) clears both stored words and all bus-hold levels to 0. Clock edges during reset load nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | A-to-B capture clock (rising edge) |
| clk_ba | input | 1 | B-to-A capture clock (rising edge) |
| rst_n | input | 1 | Asynchronous reset, active low |
| oe_ab_n | input | 1 | A-to-B output enable, active low |
| le_ab | input | 1 | A-to-B latch enable, high = flow-through |
| ce_ab_n | input | 1 | A-to-B clock enable, active low |
| oe_ba_n | input | 1 | B-to-A output enable, active low |
| le_ba | input | 1 | B-to-A latch enable, high = flow-through |
| ce_ba_n | input | 1 | B-to-A clock enable, active low |
| a_in | input | W (18) | Level seen on the A lines |
| a_in_drv | input | W (18) | Per-bit flag: the A line is driven from outside |
| a_out | output | W (18) | Value for the A tri-state drivers |
| a_oe | output | W (18) | Per-bit drive enable for the A lines |
| b_in | input | W (18) | Resolved level of the B bus |
| b_out | output | W (18) | Value for the B drivers (always 0, open-drain) |
| b_oe | output | W (18) | Per-bit pull-low enable for the B lines |

## Verification
Some results are combinational and are due in the same time step as the input change: output-enable effects, flow-through, bus-hold substitution and reset clearing. The bench applies controls and data, waits one time unit, and then performs the clock action the vector names: none, a rising edge, or a fall. It samples port levels two units later, so every check sees a settled result that no edge ordering can affect. A result loaded on a rising edge is due right after that edge, and it is read in the same step, before any further edge. Rows that must show no change hold the clock steady high or low, or apply only a falling edge.

// File: rtl/ubx_pkg.sv
package ubx_pkg;

    // Operating mode of one storage path, decoded from its enables.
    typedef enum logic [1:0] {
        MODE_FLOW    = 2'd0,
        MODE_CAPTURE = 2'd1,
        MODE_INHIBIT = 2'd2
    } mode_e;

    // Output stage variant.
    typedef enum logic {
        DRV_PUSH_PULL  = 1'b0,
        DRV_OPEN_DRAIN = 1'b1
    } drv_kind_e;

    // Latch enable outranks clock enable.
    function automatic mode_e decode_mode(input logic le, input logic ce_n);
        if (le)
            return MODE_FLOW;
        else if (!ce_n)
            return MODE_CAPTURE;
        else
            return MODE_INHIBIT;
    endfunction

endpackage

// File: rtl/ubx_store.sv
module ubx_store
    import ubx_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le,
    input  logic         ce_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q_view
);

    mode_e        mode;
    logic [W-1:0] held;
    logic [W-1:0] held_nxt;

    // Next stored word chosen by mode.
    always_comb begin
        mode = decode_mode(le, ce_n);
        unique case (mode)
            MODE_FLOW:    held_nxt = d;
            MODE_CAPTURE: held_nxt = d;
            MODE_INHIBIT: held_nxt = held;
            default:      held_nxt = held;
        endcase
    end

    // Storage register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            held <= '0;
        else
            held <= held_nxt;
    end

    // Output view: flow-through bypasses storage.
    always_comb begin
        unique case (mode)
            MODE_FLOW:    q_view = d;
            MODE_CAPTURE: q_view = held;
            MODE_INHIBIT: q_view = held;
            default:      q_view = held;
        endcase
    end

endmodule

// File: rtl/ubx_keeper.sv
module ubx_keeper #(
    parameter int W = 18
) (
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    input  logic [W-1:0] drv,
    output logic [W-1:0] level
);

    logic [W-1:0] kept;

    // Weak keeper: remembers the last driven level of each line.
    always_latch begin
        if (!rst_n) begin
            kept <= '0;
        end else begin
            for (int i = 0; i < W; i++) begin
                if (drv[i])
                    kept[i] <= pin[i];
            end
        end
    end

    assign level = (drv & pin) | (~drv & kept);

endmodule

// File: rtl/ubx_drive.sv
module ubx_drive
    import ubx_pkg::*;
#(
    parameter int        W    = 18,
    parameter drv_kind_e KIND = DRV_PUSH_PULL
) (
    input  logic         en_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] pin_val,
    output logic [W-1:0] pin_en
);

    generate
        if (KIND == DRV_OPEN_DRAIN) begin : g_open_drain
            // Only pull low; a 1 is left to the bus pull-up.
            always_comb begin
                pin_val = '0;
                pin_en  = en_n ? '0 : ~d;
            end
        end else begin : g_push_pull
            always_comb begin
                pin_val = d;
                pin_en  = {W{~en_n}};
            end
        end
    endgenerate

endmodule

// File: rtl/ubx_transceiver.sv
module ubx_transceiver
    import ubx_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk_ab,
    input  logic         clk_ba,
    input  logic         rst_n,
    input  logic         oe_ab_n,
    input  logic         le_ab,
    input  logic         ce_ab_n,
    input  logic         oe_ba_n,
    input  logic         le_ba,
    input  logic         ce_ba_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] a_in_drv,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe
);

    logic [W-1:0] a_level;
    logic [W-1:0] word_ab;
    logic [W-1:0] word_ba;

    // A-side bus-hold.
    ubx_keeper #(.W(W)) u_keep_a (
        .rst_n (rst_n),
        .pin   (a_in),
        .drv   (a_in_drv),
        .level (a_level)
    );

    // A-to-B storage path.
    ubx_store #(.W(W)) u_store_ab (
        .clk    (clk_ab),
        .rst_n  (rst_n),
        .le     (le_ab),
        .ce_n   (ce_ab_n),
        .d      (a_level),
        .q_view (word_ab)
    );

    // B-to-A storage path.
    ubx_store #(.W(W)) u_store_ba (
        .clk    (clk_ba),
        .rst_n  (rst_n),
        .le     (le_ba),
        .ce_n   (ce_ba_n),
        .d      (b_in),
        .q_view (word_ba)
    );

    // B side: open-drain.
    ubx_drive #(.W(W), .KIND(DRV_OPEN_DRAIN)) u_drv_b (
        .en_n    (oe_ab_n),
        .d       (word_ab),
        .pin_val (b_out),
        .pin_en  (b_oe)
    );

    // A side: tri-state.
    ubx_drive #(.W(W), .KIND(DRV_PUSH_PULL)) u_drv_a (
        .en_n    (oe_ba_n),
        .d       (word_ba),
        .pin_val (a_out),
        .pin_en  (a_oe)
    );

endmodule

// File: rtl/ubx_transceiver_chk.sv
module ubx_transceiver_chk #(
    parameter int W = 18
) (
    input logic         clk_ab,
    input logic         clk_ba,
    input logic         rst_n,
    input logic         oe_ab_n,
    input logic         le_ab,
    input logic         ce_ab_n,
    input logic         oe_ba_n,
    input logic         le_ba,
    input logic         ce_ba_n,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_in_drv,
    input logic [W-1:0] a_out,
    input logic [W-1:0] a_oe,
    input logic [W-1:0] b_in,
    input logic [W-1:0] b_out,
    input logic [W-1:0] b_oe
);

    assert_b_release_R2: assert property (@(posedge clk_ab) disable iff (!rst_n)
        oe_ab_n |-> (b_oe == '0));

    assert_a_release_R2: assert property (@(posedge clk_ba) disable iff (!rst_n)
        oe_ba_n |-> (a_oe == '0));

    assert_flow_R3: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (!oe_ab_n && le_ab && (&a_in_drv)) |-> (b_oe == ~a_in));

    assert_capture_R4: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (!le_ab && !ce_ab_n && (&a_in_drv)) |=>
            (le_ab || oe_ab_n || (b_oe == ~$past(a_in))));

    assert_inhibit_R6: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (!oe_ab_n && !le_ab && ce_ab_n) |=>
            (le_ab || oe_ab_n || $stable(b_oe)));

    assert_mirror_capture_R1: assert property (@(posedge clk_ba) disable iff (!rst_n)
        (!le_ba && !ce_ba_n) |=> (le_ba || (a_out == $past(b_in))));

    assert_open_drain_R8: assert property (@(posedge clk_ab) disable iff (!rst_n)
        1'b1 |-> (b_out == '0));

endmodule

bind ubx_transceiver ubx_transceiver_chk #(.W(W)) u_chk (.*);

// File: tb/sim_ubx_transceiver.sv
`timescale 1ns/1ps
module sim_ubx_transceiver;

    localparam int W = 18;
    localparam logic [W-1:0] ONES = '1;
    localparam logic [1:0] OP_KEEP = 2'd0;
    localparam logic [1:0] OP_RISE = 2'd1;
    localparam logic [1:0] OP_FALL = 2'd2;

    typedef struct packed {
        logic         oe_n;
        logic         le;
        logic         ce_n;
        logic [1:0]   op;
        logic [W-1:0] d;
        logic [W-1:0] x;
    } vec_t;

    // Same table drives both directions (R1).
    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b0, OP_KEEP, 18'h3FFFF, 18'h3FFFF}, // R2 disabled
        '{1'b0, 1'b0, 1'b0, OP_KEEP, 18'h3FFFF, 18'h00000}, // R10 R5 reset word, clk low
        '{1'b0, 1'b1, 1'b1, OP_KEEP, 18'h2A5F3, 18'h2A5F3}, // R3
        '{1'b0, 1'b1, 1'b1, OP_KEEP, 18'h15A0C, 18'h15A0C}, // R3
        '{1'b0, 1'b1, 1'b1, OP_RISE, 18'h15A0C, 18'h15A0C}, // R7 edge in flow
        '{1'b0, 1'b0, 1'b1, OP_KEEP, 18'h00FF0, 18'h15A0C}, // R7 R5 clk high
        '{1'b0, 1'b0, 1'b1, OP_RISE, 18'h00FF0, 18'h15A0C}, // R6
        '{1'b0, 1'b0, 1'b0, OP_KEEP, 18'h00FF0, 18'h15A0C}, // R5
        '{1'b0, 1'b0, 1'b0, OP_RISE, 18'h00FF0, 18'h00FF0}, // R4
        '{1'b0, 1'b0, 1'b0, OP_RISE, 18'h3C3C3, 18'h3C3C3}, // R4 R8
        '{1'b0, 1'b0, 1'b0, OP_FALL, 18'h12345, 18'h3C3C3}, // R4 R5 falling edge
        '{1'b1, 1'b0, 1'b0, OP_KEEP, 18'h12345, 18'h3FFFF}, // R2
        '{1'b0, 1'b0, 1'b0, OP_KEEP, 18'h12345, 18'h3C3C3}, // R2 word kept
        '{1'b1, 1'b1, 1'b0, OP_RISE, 18'h00000, 18'h3FFFF}, // R2 over flow
        '{1'b0, 1'b0, 1'b1, OP_KEEP, 18'h3FFFF, 18'h00000}  // R7
    };

    logic clk = 1'b0;
    logic clk_ab = 1'b0, clk_ba = 1'b0, rst_n = 1'b0;
    logic oe_ab_n = 1'b1, le_ab = 1'b0, ce_ab_n = 1'b1;
    logic oe_ba_n = 1'b1, le_ba = 1'b0, ce_ba_n = 1'b1;
    logic [W-1:0] a_in = '0, a_in_drv = '1, b_in = '0;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;

    int n_cmp = 0, n_bad = 0, cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ubx_transceiver #(.W(W)) u0 (
        .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n),
        .oe_ab_n(oe_ab_n), .le_ab(le_ab), .ce_ab_n(ce_ab_n),
        .oe_ba_n(oe_ba_n), .le_ba(le_ba), .ce_ba_n(ce_ba_n),
        .a_in(a_in), .a_in_drv(a_in_drv), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    // Line levels with a pull-up on undriven bits.
    function automatic logic [W-1:0] b_level();
        return (b_oe & b_out) | ~b_oe;
    endfunction
    function automatic logic [W-1:0] a_level();
        return (a_oe & a_out) | ~a_oe;
    endfunction

    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %05h expected %05h", req, got, exp);
        end
    endtask

    task automatic clk_op(ref logic c, input logic [1:0] op);
        case (op)
            OP_RISE: begin
                if (c) begin c = 1'b0; #1; end
                c = 1'b1;
            end
            OP_FALL: c = 1'b0;
            default: ;
        endcase
    endtask

    task automatic apply_ab(input vec_t v);
        oe_ab_n = v.oe_n; le_ab = v.le; ce_ab_n = v.ce_n; a_in = v.d;
        #1; clk_op(clk_ab, v.op); #2;
    endtask

    task automatic apply_ba(input vec_t v);
        oe_ba_n = v.oe_n; le_ba = v.le; ce_ba_n = v.ce_n; b_in = v.d;
        #1; clk_op(clk_ba, v.op); #2;
    endtask

    task automatic pulse(ref logic c);
        c = 1'b0; #1; c = 1'b1; #1; c = 1'b0; #1;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got %0d cycles expected at most 20000", cycles);
            finish_run();
        end
    end

    logic [W-1:0] first, mixed;

    initial begin
        #5;
        // R10 R2: after reset, everything released.
        check("R2 b_oe in reset", b_oe, '0);
        check("R2 a_oe in reset", a_oe, '0);
        rst_n = 1'b1; #3;

        // A-to-B table.
        for (int i = 0; i < NV; i++) begin
            apply_ab(VECS[i]);
            check($sformatf("AB vec %0d", i), b_level(), VECS[i].x);
        end
        oe_ab_n = 1'b1; #2;
        check("R8 b_out always 0", b_out, '0);

        // B-to-A mirror (R1).
        for (int i = 0; i < NV; i++) begin
            apply_ba(VECS[i]);
            check($sformatf("R1 BA vec %0d", i), a_level(), VECS[i].x);
        end

        // R1 independence: AB capture leaves BA untouched, and back.
        oe_ab_n = 1'b0; le_ab = 1'b0; ce_ab_n = 1'b0; a_in = 18'h0ABCD;
        oe_ba_n = 1'b0; le_ba = 1'b0; ce_ba_n = 1'b1; b_in = 18'h3FFFF;
        #1; pulse(clk_ab); #1;
        check("R1 AB capture", b_level(), 18'h0ABCD);
        check("R1 BA untouched", a_level(), 18'h00000);
        ce_ba_n = 1'b0; b_in = 18'h3A1B2; #1; pulse(clk_ba); #1;
        check("R1 BA capture", a_level(), 18'h3A1B2);
        check("R1 AB untouched", b_level(), 18'h0ABCD);

        // R9 bus-hold on A inputs (flow-through, BA released).
        oe_ba_n = 1'b1; le_ab = 1'b1; ce_ab_n = 1'b1;
        a_in = 18'h2AAAA; a_in_drv = '1; #2;
        first = 18'h2AAAA;
        check("R9 driven", b_level(), first);
        a_in_drv = 18'h3FE00; a_in = 18'h15555; #2;
        mixed = (18'h15555 & 18'h3FE00) | (first & ~18'h3FE00);
        check("R9 partly held", b_level(), mixed);
        a_in_drv = '0; a_in = '0; #2;
        check("R9 all held", b_level(), mixed);
        a_in_drv = '1; a_in = 18'h3C00F; #2;
        check("R9 re-driven", b_level(), 18'h3C00F);

        // R10 reset clears stored words; edges in reset load nothing.
        le_ab = 1'b0; ce_ab_n = 1'b0; oe_ba_n = 1'b0; b_in = 18'h3FFFF;
        #1; rst_n = 1'b0; #1;
        pulse(clk_ab); pulse(clk_ba);
        rst_n = 1'b1; #2;
        check("R10 AB cleared", b_level(), 18'h00000);
        check("R10 BA cleared", a_level(), 18'h00000);

        done = 1'b1;
        finish_run();
    end

endmodule